// File: doc/BRIEF.md
# PLL Fastlock Timeout Controller

This block sequences the fastlock phase of a frequency synthesizer loop. It sits behind the loop's reference configuration word and counts phase-detector strobes. When a new frequency word is loaded and at least one switch is set to fastlock mode, it starts a programmable timeout. While the timeout runs, it selects a boosted charge-pump current and pulls the fastlock-mode switch outputs low. These outputs switch extra loop-filter damping into the loop. When the count expires, the block returns the pump to its nominal current and releases the switches.

The timeout counter is ten bits wide. Only its upper seven bits are preset from the configuration word and its lower three bits load as zero, so the programmed value sets the timeout in steps of eight phase-detector cycles. A switch that is not in fastlock mode works as a general-purpose static output that copies its level bit.

Top module: `fastlock_timer`

## Requirements
- R1: Field positions in `ref_word`: the timeout value is bits [20:14]. The switch-2 fastlock-mode enable is bit 13 and the switch-1 enable is bit 12. The switch-2 static level is bit 11 and the switch-1 static level is bit 10.
- R2: The timeout lasts exactly 8 × (programmed value) cycles in which `pd_tick` is high. Cycles without `pd_tick` do not advance it, and `to_active` stays high throughout.
- R3: A `freq_load` pulse with either enable bit high raises `to_active` on the next cycle. A `freq_load` with both enable bits low leaves the block idle.
- R4: A `freq_load` that arrives while the timeout is active restarts the full timeout from the programmed value.
- R5: `to_done` is high for exactly one cycle, in the cycle in which `to_active` has just fallen after the final strobe. After that the block stays idle until the next load.
- R6: A programmed value below 3 is treated as 3, which gives a timeout of 24 strobes.
- R7: A switch whose enable bit is high outputs 0 while `to_active` is high and 1 otherwise. Its static level bit has no effect.
- R8: A switch whose enable bit is low outputs its static level bit at all times, including during a timeout.
- R9: While active, `gain_hi` is 1 and `cp_mult` equals 4, 7 or 9 for `boost_sel` 0, 1 or 2 (a `boost_sel` of 3 gives 9). While idle, `gain_hi` is 0 and `cp_mult` is 1 whatever `boost_sel` holds.
- R10: A synchronous active-low `rst_n` makes the block idle: `to_active` and `to_done` go low and both switches follow the R7/R8 idle rules.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pd_tick | input | 1 | Phase-detector cycle strobe |
| freq_load | input | 1 | New frequency word loaded (one-cycle pulse) |
| ref_word | input | 21 | Reference configuration word (fields per R1) |
| boost_sel | input | 2 | Boosted charge-pump multiplier choice |
| gain_hi | output | 1 | High charge-pump gain select |
| cp_mult | output | 4 | Charge-pump current multiplier of nominal |
| sw1_out | output | 1 | Loop-filter switch 1 output |
| sw2_out | output | 1 | Loop-filter switch 2 output |
| to_active | output | 1 | Timeout running |
| to_done | output | 1 | One-cycle pulse at timeout end |

## Verification
The bench counts strobes until the end of each timeout, both with a strobe every cycle and with strobes every other cycle. An off-by-one counter, or a counter that runs on the clock rather than on the strobe, would give 23, 25 or too few strobes. Programmed values 0, 1 and 2 must give 24 strobes, so a missing clamp would end early or never start. A reload partway through a timeout must run a full 24 strobes again, which a design that ignores loads while busy would fail. The bench also changes the static bits during a timeout: a switch in fastlock mode must stay low, and a switch outside it must follow its bit.

// File: rtl/fastlock_timer.sv
module fastlock_timer #(
  parameter int VAL_W    = 7,
  parameter int FRAC_W   = 3,
  parameter int MIN_VAL  = 3,
  parameter int MULT_W   = 4,
  parameter int MULT_NOM = 1,
  parameter int MULT_LO  = 4,
  parameter int MULT_MID = 7,
  parameter int MULT_HI  = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pd_tick,
  input  logic              freq_load,
  input  logic [13+VAL_W:0] ref_word,
  input  logic [1:0]        boost_sel,
  output logic              gain_hi,
  output logic [MULT_W-1:0] cp_mult,
  output logic              sw1_out,
  output logic              sw2_out,
  output logic              to_active,
  output logic              to_done
);
  localparam int CNT_W   = VAL_W + FRAC_W;
  localparam int VAL_LSB = 14;
  localparam int EN_LSB  = 12;
  localparam int ST_LSB  = 10;

  logic [VAL_W-1:0]  val_raw, val_eff;
  logic [1:0]        sw_en, sw_st, sw_q;
  logic              start, last;
  logic [CNT_W-1:0]  cnt;
  logic              act, done;
  logic [MULT_W-1:0] boost;

  assign val_raw = ref_word[VAL_LSB +: VAL_W];
  assign val_eff = (val_raw < VAL_W'(MIN_VAL)) ? VAL_W'(MIN_VAL) : val_raw;
  assign sw_en   = ref_word[EN_LSB +: 2];
  assign sw_st   = ref_word[ST_LSB +: 2];
  assign start   = freq_load & (|sw_en);
  assign last    = (cnt == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      act  <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        cnt <= {val_eff, {FRAC_W{1'b0}}};
        act <= 1'b1;
      end else if (act && pd_tick) begin
        cnt <= cnt - CNT_W'(1);
        if (last) begin
          act  <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    case (boost_sel)
      2'd0:    boost = MULT_W'(MULT_LO);
      2'd1:    boost = MULT_W'(MULT_MID);
      default: boost = MULT_W'(MULT_HI);
    endcase
  end

  for (genvar i = 0; i < 2; i++) begin : g_sw
    assign sw_q[i] = sw_en[i] ? ~act : sw_st[i];
  end

  assign gain_hi   = act;
  assign cp_mult   = act ? boost : MULT_W'(MULT_NOM);
  assign sw1_out   = sw_q[0];
  assign sw2_out   = sw_q[1];
  assign to_active = act;
  assign to_done   = done;
endmodule

// File: rtl/fastlock_timer_chk.sv
module fastlock_timer_chk #(
  parameter int VAL_W = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pd_tick,
  input logic              freq_load,
  input logic [13+VAL_W:0] ref_word,
  input logic              sw1_out,
  input logic              sw2_out,
  input logic              to_active,
  input logic              to_done
);
  AST_START_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (freq_load && (ref_word[13] || ref_word[12])) |=> to_active); // R3
  AST_NO_START_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (!to_active && freq_load && !ref_word[13] && !ref_word[12]) |=> !to_active); // R3
  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (to_active && !pd_tick) |=> to_active); // R2
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    to_done |=> !to_done); // R5
  AST_END_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(to_active) |-> to_done); // R5
  AST_SW1_LOW_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (to_active && ref_word[12]) |-> !sw1_out); // R7
  AST_SW2_LOW_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (to_active && ref_word[13]) |-> !sw2_out); // R7
  AST_RESET_IDLE: assert property (@(posedge clk)
    !rst_n |=> (!to_active && !to_done)); // R10
endmodule

bind fastlock_timer fastlock_timer_chk #(.VAL_W(VAL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pd_tick(pd_tick), .freq_load(freq_load),
  .ref_word(ref_word), .sw1_out(sw1_out), .sw2_out(sw2_out),
  .to_active(to_active), .to_done(to_done)
);

// File: tb/fastlock_timer_bench.sv
`timescale 1ns/1ps
module fastlock_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pd_tick = 1'b0;
  logic        freq_load = 1'b0;
  logic [20:0] ref_word = '0;
  logic [1:0]  boost_sel = '0;
  logic        gain_hi, sw1_out, sw2_out, to_active, to_done;
  logic [3:0]  cp_mult;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  fastlock_timer u_fastlock_timer (
    .clk(clk), .rst_n(rst_n), .pd_tick(pd_tick), .freq_load(freq_load),
    .ref_word(ref_word), .boost_sel(boost_sel), .gain_hi(gain_hi),
    .cp_mult(cp_mult), .sw1_out(sw1_out), .sw2_out(sw2_out),
    .to_active(to_active), .to_done(to_done)
  );

  // {val[6:0], boost[1:0], en{2,1}, st{2,1}, gap, exp_ticks[9:0], exp_mult[3:0]}
  localparam logic [27:0] VEC [8] = '{
    {7'd3,   2'd0, 2'b01, 2'b10, 1'b0, 10'd24,   4'd4},
    {7'd5,   2'd1, 2'b10, 2'b01, 1'b0, 10'd40,   4'd7},
    {7'd0,   2'd2, 2'b11, 2'b00, 1'b0, 10'd24,   4'd9},
    {7'd2,   2'd3, 2'b01, 2'b11, 1'b1, 10'd24,   4'd9},
    {7'd127, 2'd0, 2'b11, 2'b11, 1'b0, 10'd1016, 4'd4},
    {7'd64,  2'd1, 2'b10, 2'b00, 1'b1, 10'd512,  4'd7},
    {7'd10,  2'd2, 2'b01, 2'b01, 1'b0, 10'd80,   4'd9},
    {7'd1,   2'd0, 2'b10, 2'b10, 1'b0, 10'd24,   4'd4}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic set_cfg(input logic [6:0] v, input logic [1:0] en, input logic [1:0] st);
    ref_word = {v, en, st, 10'd0};
  endtask

  function automatic logic sw_exp(input logic en, input logic st, input logic act);
    return en ? ~act : st;
  endfunction

  task automatic count_ticks(input bit gap, output int n);
    int cyc = 0;
    n = 0;
    while (to_active && cyc < 5000) begin
      pd_tick = gap ? cyc[0] : 1'b1;
      if (pd_tick) n++;
      step();
      cyc++;
      if (!to_active) chk(to_done == 1'b1, "R5 done at end", to_done, 1);
    end
    pd_tick = 1'b0;
  endtask

  initial begin
    #600000;
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int n;
    set_cfg(7'd3, 2'b00, 2'b11);
    repeat (4) step();
    chk(to_active == 1'b0, "R10 reset active", to_active, 0);
    chk(to_done == 1'b0, "R10 reset done", to_done, 0);
    chk(cp_mult == 4'd1 && gain_hi == 1'b0, "R10 reset gain", cp_mult, 1);
    chk(sw1_out == 1'b1 && sw2_out == 1'b1, "R10 reset switches", {sw2_out, sw1_out}, 3);
    rst_n = 1'b1;
    step();

    freq_load = 1'b1;
    step();
    freq_load = 1'b0;
    #1;
    chk(to_active == 1'b0, "R3 load with fastlock disabled", to_active, 0);
    chk(sw1_out == 1'b1 && sw2_out == 1'b1, "R8 static level 1", {sw2_out, sw1_out}, 3);
    set_cfg(7'd3, 2'b00, 2'b00);
    #1;
    chk(sw1_out == 1'b0 && sw2_out == 1'b0, "R8 static level 0", {sw2_out, sw1_out}, 0);

    foreach (VEC[i]) begin
      logic [6:0] v;
      logic [1:0] bs, en, st;
      logic       gp;
      logic [9:0] et;
      logic [3:0] em;
      {v, bs, en, st, gp, et, em} = VEC[i];
      set_cfg(v, en, st);
      boost_sel = bs;
      freq_load = 1'b1;
      step();
      freq_load = 1'b0;
      #1;
      chk(to_active == 1'b1, "R3 start", to_active, 1);
      chk(gain_hi == 1'b1 && cp_mult == em, "R9 boost mult", cp_mult, em);
      chk(sw1_out == sw_exp(en[0], st[0], 1'b1), "R7/R8 sw1 active", sw1_out, sw_exp(en[0], st[0], 1'b1));
      chk(sw2_out == sw_exp(en[1], st[1], 1'b1), "R7/R8 sw2 active", sw2_out, sw_exp(en[1], st[1], 1'b1));
      count_ticks(gp, n);
      chk(n == int'(et), "R2/R6 timeout strobes", n, et);
      #1;
      chk(gain_hi == 1'b0 && cp_mult == 4'd1, "R9 nominal after end", cp_mult, 1);
      chk(sw1_out == sw_exp(en[0], st[0], 1'b0), "R7/R8 sw1 idle", sw1_out, sw_exp(en[0], st[0], 1'b0));
      chk(sw2_out == sw_exp(en[1], st[1], 1'b0), "R7/R8 sw2 idle", sw2_out, sw_exp(en[1], st[1], 1'b0));
      step();
      chk(to_done == 1'b0 && to_active == 1'b0, "R5 single pulse then idle", to_done, 0);
    end

    // R4 restart mid-timeout
    set_cfg(7'd3, 2'b01, 2'b00);
    freq_load = 1'b1;
    step();
    freq_load = 1'b0;
    pd_tick = 1'b1;
    repeat (10) step();
    pd_tick = 1'b0;
    freq_load = 1'b1;
    step();
    freq_load = 1'b0;
    count_ticks(1'b0, n);
    chk(n == 24, "R4 reload restarts full timeout", n, 24);
    step();

    // R2 no advance without strobe; R7/R8 static bits changed during timeout
    set_cfg(7'd3, 2'b01, 2'b00);
    freq_load = 1'b1;
    step();
    freq_load = 1'b0;
    repeat (50) step();
    chk(to_active == 1'b1, "R2 holds without strobe", to_active, 1);
    set_cfg(7'd3, 2'b01, 2'b11);
    #1;
    chk(sw1_out == 1'b0, "R7 static bit ignored when enabled", sw1_out, 0);
    chk(sw2_out == 1'b1, "R8 follows static bit during timeout", sw2_out, 1);
    chk(cp_mult == 4'd4, "R9 boost_sel 0 mid-timeout", cp_mult, 4);
    boost_sel = 2'd2;
    #1;
    chk(cp_mult == 4'd9, "R9 boost_sel 2 mid-timeout", cp_mult, 9);

    // R10 reset mid-timeout
    rst_n = 1'b0;
    repeat (3) step();
    chk(to_active == 1'b0 && to_done == 1'b0, "R10 reset clears timeout", to_active, 0);
    chk(sw1_out == 1'b1 && sw2_out == 1'b1, "R10 switches idle after reset", {sw2_out, sw1_out}, 3);
    chk(cp_mult == 4'd1, "R9 idle mult ignores boost_sel", cp_mult, 1);
    rst_n = 1'b1;
    step();

    // R1 field check: value in [20:14] only, enable at bit 13 drives sw2
    ref_word = 21'd0;
    ref_word[20:14] = 7'd4;
    ref_word[13] = 1'b1;
    freq_load = 1'b1;
    step();
    freq_load = 1'b0;
    #1;
    chk(sw2_out == 1'b0 && sw1_out == 1'b0, "R1 enable bit 13 selects sw2", {sw2_out, sw1_out}, 0);
    count_ticks(1'b0, n);
    chk(n == 32, "R1 value field bits 20:14", n, 32);
    step();

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule